// File: doc/BRIEF.md
# Touch-ADC Scan Sequencer

This block is an SPI master for an external resistive touch-screen converter with eight multiplexed inputs. A single start pulse launches one scan over the channels selected by an 8-bit enable mask. For each selected channel the block sends a group of back-to-back 24-bit frames. Each frame carries an 8-bit command followed by a 16-bit response window. The first frames of the group let the input settle and are discarded. The remaining frames are summed, and the sum is divided with upward rounding into one 12-bit result.

Settling and oversampling counts are given per channel, so slow plates can be given more settling frames than fast auxiliary inputs. A reference-select input says whether the converter's internal reference is in use. The scan ends with a one-cycle done pulse. The results stay on the output, packed in ascending channel order, until the next scan begins.

Top module: `touch_scan_seq`

## Requirements
- R1: Every command byte has bit 7 set to 1 and bit 3 (conversion width) cleared to 0. Bits 6:4 hold the channel address.
- R2: Bit 2 of the command is 1 (single-ended) for addresses 0, 2, 6 and 7, and 0 (differential) for addresses 1, 3, 4 and 5.
- R3: On every frame except the last of a group, bit 1 (reference on) equals the single-ended condition of R2 ANDed with the reference-select input.
- R4: Bit 0 (converter on) is 1 on every frame of a group except the last. The last frame of a group has bits 1:0 both 0.
- R5: A group sends exactly skip + over frames, where `over` is the channel's oversampling count and a count of 0 is treated as 1. The first `skip` responses of the group are discarded.
- R6: The 12-bit sample is taken from response bits 14:3 (the response is MSB first). The channel result is ceil(sum of kept samples / over).
- R7: Enabled channels are scanned in ascending address order. Output slot g (bits 12g+11:12g) holds the result of the g-th enabled channel, and slots beyond the enabled count read 0.
- R8: The bus runs in SPI mode 0. The clock idles low and each half period lasts HALF_DIV clock cycles. MOSI changes only while the clock is low, and MISO is sampled on the rising edge.
- R9: Chip select goes low before the first frame and stays low across all groups of the scan. It rises exactly one clock cycle after the final falling edge of the serial clock.
- R10: The done output is a single-cycle pulse, and results are valid in that cycle. An all-zero mask produces done with no frame and no chip-select activity.
- R11: The mask, counts and reference select are captured at start. A start pulse or input change during a scan has no effect on the running scan and starts no further scan.
- R12: After reset, chip select is high, the serial clock is low, done is low and all result slots read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a scan |
| ch_en_i | input | NUM_CH | Channel enable mask, bit c selects address c |
| skip_cnt_i | input | NUM_CH*CNT_W | Settling frames per channel, channel c at bits c*CNT_W +: CNT_W |
| ovs_cnt_i | input | NUM_CH*CNT_W | Averaged frames per channel, same packing |
| int_ref_i | input | 1 | 1 when the converter's internal reference is used |
| miso_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data to the converter |
| result_o | output | NUM_CH*12 | Packed results, slot g at bits 12g +: 12 |
| done_o | output | 1 | One-cycle pulse at scan end |

## Verification
The bus-level properties assume that miso_i is a clean synchronous input. They also assume that start_i is a single-cycle pulse, and they place no constraint on when that pulse arrives. The converter model in the bench changes MISO only after a falling serial-clock edge. Its responses depend only on the address it decoded and the frame's position in the group, so every expected sum can be computed with plain arithmetic. A second start is injected only while chip select is low, and the configuration inputs are changed at the same moment. This keeps the stimulus within those assumptions while still testing that the capture at start holds.

// File: rtl/touch_scan_pkg.sv
package touch_scan_pkg;

    localparam int SAMPLE_W   = 12;
    localparam int FRAME_BITS = 24;
    localparam int CMD_BITS   = 8;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LAUNCH,
        SQ_WAIT,
        SQ_DSTART,
        SQ_DWAIT
    } seq_st_e;

    // Inputs measured against their own reference pin use the single-ended path.
    function automatic logic is_single_ended(input logic [2:0] addr);
        return (addr == 3'd0) || (addr == 3'd2) || (addr == 3'd6) || (addr == 3'd7);
    endfunction

    // Last frame of a group drops both power bits so the converter sleeps.
    function automatic logic [CMD_BITS-1:0] build_cmd(input logic [2:0] addr,
                                                      input logic       int_ref,
                                                      input logic       last_frame);
        logic se;
        se = is_single_ended(addr);
        return {1'b1, addr, 1'b0, se, (~last_frame & se & int_ref), ~last_frame};
    endfunction

endpackage

// File: rtl/touch_spi_frame.sv
module touch_spi_frame
    import touch_scan_pkg::*;
#(
    parameter int HALF_DIV = 21
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                go_i,
    input  logic [CMD_BITS-1:0] cmd_i,
    input  logic                miso_i,
    output logic                sclk_o,
    output logic                mosi_o,
    output logic                fin_o,
    output logic [SAMPLE_W-1:0] data_o
);
    localparam int HC_W  = $clog2(HALF_DIV + 1);
    localparam int BIT_W = $clog2(FRAME_BITS);

    typedef struct packed {
        logic                active;
        logic                sclk;
        logic                fin;
        logic [HC_W-1:0]     hcnt;
        logic [BIT_W-1:0]    bitn;
        logic [CMD_BITS-1:0] tx;
        logic [14:0]         rx;
    } frm_t;

    frm_t q, d;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        if (!q.active) begin
            if (go_i) begin
                d.active = 1'b1;
                d.sclk   = 1'b0;
                d.hcnt   = '0;
                d.bitn   = '0;
                d.tx     = cmd_i;
            end
        end else if (q.hcnt == HC_W'(HALF_DIV - 1)) begin
            d.hcnt = '0;
            if (!q.sclk) begin
                d.sclk = 1'b1;
                d.rx   = {q.rx[13:0], miso_i};
            end else begin
                d.sclk = 1'b0;
                if (q.bitn == BIT_W'(FRAME_BITS - 1)) begin
                    d.active = 1'b0;
                    d.fin    = 1'b1;
                end else begin
                    d.bitn = q.bitn + BIT_W'(1);
                    d.tx   = {q.tx[CMD_BITS-2:0], 1'b0};
                end
            end
        end else begin
            d.hcnt = q.hcnt + HC_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign sclk_o = q.sclk;
    assign mosi_o = q.tx[CMD_BITS-1];
    assign fin_o  = q.fin;
    assign data_o = q.rx[14:3];

endmodule

// File: rtl/touch_ceil_div.sv
module touch_ceil_div #(
    parameter int NW = 17,
    parameter int DW = 4,
    parameter int QW = 12
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          go_i,
    input  logic [NW-1:0] num_i,
    input  logic [DW-1:0] den_i,
    output logic [QW-1:0] quot_o,
    output logic          done_o
);
    localparam int CW = $clog2(NW + 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [DW-1:0] rem;
        logic [NW-1:0] q;
        logic [DW-1:0] den;
    } div_t;

    div_t q, d;
    logic [DW:0] rem_sh;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        rem_sh = {q.rem, q.q[NW-1]};
        if (go_i && !q.busy) begin
            d.busy = 1'b1;
            d.cnt  = '0;
            d.rem  = '0;
            d.q    = num_i;
            d.den  = den_i;
        end else if (q.busy) begin
            if (rem_sh >= {1'b0, q.den}) begin
                d.rem = DW'(rem_sh - {1'b0, q.den});
                d.q   = {q.q[NW-2:0], 1'b1};
            end else begin
                d.rem = rem_sh[DW-1:0];
                d.q   = {q.q[NW-2:0], 1'b0};
            end
            d.cnt = q.cnt + CW'(1);
            if (q.cnt == CW'(NW - 1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign quot_o = q.q[QW-1:0];
    assign done_o = q.done;

endmodule

// File: rtl/touch_scan_seq.sv
module touch_scan_seq
    import touch_scan_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int CNT_W    = 4,
    parameter int HALF_DIV = 21
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         start_i,
    input  logic [NUM_CH-1:0]            ch_en_i,
    input  logic [NUM_CH*CNT_W-1:0]      skip_cnt_i,
    input  logic [NUM_CH*CNT_W-1:0]      ovs_cnt_i,
    input  logic                         int_ref_i,
    input  logic                         miso_i,
    output logic                         sclk_o,
    output logic                         cs_n_o,
    output logic                         mosi_o,
    output logic [NUM_CH*SAMPLE_W-1:0]   result_o,
    output logic                         done_o
);
    localparam int CH_W  = $clog2(NUM_CH);
    localparam int K_W   = CNT_W + 1;
    localparam int SUM_W = SAMPLE_W + CNT_W;
    localparam int NUM_W = SUM_W + 1;

    typedef struct packed {
        seq_st_e                              st;
        logic [CH_W-1:0]                      ch;
        logic [CH_W-1:0]                      grp;
        logic [K_W-1:0]                       k;
        logic [SUM_W-1:0]                     sum;
        logic [NUM_CH-1:0]                    mask;
        logic [NUM_CH-1:0][CNT_W-1:0]         skip;
        logic [NUM_CH-1:0][CNT_W-1:0]         ovs;
        logic                                 iref;
        logic                                 cs_n;
        logic                                 done;
        logic [NUM_CH-1:0][SAMPLE_W-1:0]      res;
    } seq_t;

    seq_t q, d;

    // Lowest enabled index at or above lo; MSB flags a hit.
    function automatic logic [CH_W:0] pick_next(input logic [NUM_CH-1:0] m, input int lo);
        logic [CH_W:0] r;
        r = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (i >= lo && m[i]) r = {1'b1, CH_W'(i)};
        end
        return r;
    endfunction

    logic [CNT_W-1:0]    ovs_eff;
    logic [K_W-1:0]      last_k;
    logic                is_last;
    logic [CH_W:0]       nxt;
    logic [CH_W:0]       first;
    logic                frame_go;
    logic                frame_fin;
    logic [CMD_BITS-1:0] frame_cmd;
    logic [SAMPLE_W-1:0] frame_data;
    logic                div_go;
    logic                div_done;
    logic [NUM_W-1:0]    div_num;
    logic [SAMPLE_W-1:0] div_quot;

    always_comb begin
        ovs_eff   = (q.ovs[q.ch] == '0) ? CNT_W'(1) : q.ovs[q.ch];
        last_k    = K_W'(q.skip[q.ch]) + K_W'(ovs_eff) - K_W'(1);
        is_last   = (q.k == last_k);
        nxt       = pick_next(q.mask, int'(q.ch) + 1);
        first     = pick_next(ch_en_i, 0);
        frame_go  = (q.st == SQ_LAUNCH);
        frame_cmd = build_cmd(3'(q.ch), q.iref, is_last);
        div_go    = (q.st == SQ_DSTART);
        div_num   = NUM_W'(q.sum) + NUM_W'(ovs_eff) - NUM_W'(1);
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            SQ_IDLE: begin
                if (start_i) begin
                    d.mask = ch_en_i;
                    d.iref = int_ref_i;
                    for (int c = 0; c < NUM_CH; c++) begin
                        d.skip[c] = skip_cnt_i[c*CNT_W +: CNT_W];
                        d.ovs[c]  = ovs_cnt_i[c*CNT_W +: CNT_W];
                    end
                    d.res = '0;
                    d.grp = '0;
                    d.k   = '0;
                    d.sum = '0;
                    if (first[CH_W]) begin
                        d.ch   = first[CH_W-1:0];
                        d.cs_n = 1'b0;
                        d.st   = SQ_LAUNCH;
                    end else begin
                        d.done = 1'b1;
                    end
                end
            end
            SQ_LAUNCH: d.st = SQ_WAIT;
            SQ_WAIT: begin
                if (frame_fin) begin
                    if (q.k >= K_W'(q.skip[q.ch])) d.sum = q.sum + SUM_W'(frame_data);
                    if (is_last) begin
                        d.st = SQ_DSTART;
                        if (!nxt[CH_W]) d.cs_n = 1'b1;
                    end else begin
                        d.k  = q.k + K_W'(1);
                        d.st = SQ_LAUNCH;
                    end
                end
            end
            SQ_DSTART: d.st = SQ_DWAIT;
            SQ_DWAIT: begin
                if (div_done) begin
                    d.res[q.grp] = div_quot;
                    d.grp        = q.grp + CH_W'(1);
                    if (nxt[CH_W]) begin
                        d.ch  = nxt[CH_W-1:0];
                        d.k   = '0;
                        d.sum = '0;
                        d.st  = SQ_LAUNCH;
                    end else begin
                        d.done = 1'b1;
                        d.st   = SQ_IDLE;
                    end
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    touch_spi_frame #(.HALF_DIV(HALF_DIV)) u_frame (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .go_i   (frame_go),
        .cmd_i  (frame_cmd),
        .miso_i (miso_i),
        .sclk_o (sclk_o),
        .mosi_o (mosi_o),
        .fin_o  (frame_fin),
        .data_o (frame_data)
    );

    touch_ceil_div #(.NW(NUM_W), .DW(CNT_W), .QW(SAMPLE_W)) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .go_i   (div_go),
        .num_i  (div_num),
        .den_i  (ovs_eff),
        .quot_o (div_quot),
        .done_o (div_done)
    );

    assign cs_n_o   = q.cs_n;
    assign done_o   = q.done;
    assign result_o = q.res;

endmodule

// File: rtl/touch_scan_seq_chk.sv
module touch_scan_seq_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic sclk_o,
    input logic cs_n_o,
    input logic mosi_o,
    input logic done_o
);
    // R8
    sclk_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_n_o |-> !sclk_o);

    // R8
    mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

    // R10
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R9
    done_cs_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> cs_n_o);

    // R9
    cs_rise_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cs_n_o) |-> !$past(sclk_o));

endmodule

bind touch_scan_seq touch_scan_seq_chk u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_o (sclk_o),
    .cs_n_o (cs_n_o),
    .mosi_o (mosi_o),
    .done_o (done_o)
);

// File: tb/touch_scan_seq_bench.sv
module touch_scan_seq_bench;
    localparam int NUM_CH = 8;
    localparam int CNT_W  = 3;
    localparam int HALF   = 2;
    localparam int CLK_T  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NUM_CH-1:0] ch_en = '0;
    logic [NUM_CH*CNT_W-1:0] skip_r = '0;
    logic [NUM_CH*CNT_W-1:0] ovs_r = '0;
    logic iref = 1'b0;
    logic miso = 1'b0;
    logic sclk, cs_n, mosi, done;
    logic [NUM_CH*12-1:0] result;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_T/2) clk = ~clk;

    touch_scan_seq #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .HALF_DIV(HALF)) u_touch_scan_seq (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ch_en_i(ch_en),
        .skip_cnt_i(skip_r), .ovs_cnt_i(ovs_r), .int_ref_i(iref), .miso_i(miso),
        .sclk_o(sclk), .cs_n_o(cs_n), .mosi_o(mosi), .result_o(result), .done_o(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [11:0] mval(input int a, input int k, input int s);
        if (s == 200) return 12'hFFF;
        if (s == 201) return 12'h000;
        return 12'((a * 509 + k * 173 + s * 97 + 11) % 4096);
    endfunction

    // Converter model
    int seed = 0;
    int kcnt [8];
    logic [7:0] log_cmd [128];
    int log_n = 0;
    int bidx = 0;
    logic [7:0] shc = '0;
    logic [15:0] resp = '0;
    logic sclk_p = 1'b0;
    logic cs_p = 1'b1;
    longint rise_t = 0, fall_t = 0, cs_rise_t = 0;
    int bad_half = 0;

    initial begin
        forever begin
            @(sclk or cs_n);
            if (!cs_n && cs_p) bidx = 0;
            if (cs_n && !cs_p) cs_rise_t = $time;
            if (sclk && !sclk_p) begin
                rise_t = $time;
                if (bidx % 24 < 8) shc = {shc[6:0], mosi};
                bidx++;
            end
            if (!sclk && sclk_p) begin
                int pos;
                if ($time - rise_t != HALF * CLK_T) bad_half++;
                fall_t = $time;
                pos = bidx % 24;
                if (pos == 8) begin
                    int a;
                    a = int'(shc[6:4]);
                    resp = {1'b0, mval(a, kcnt[a], seed), 3'b000};
                    kcnt[a]++;
                    if (log_n < 128) log_cmd[log_n] = shc;
                    log_n++;
                end
                miso = (pos >= 8) ? resp[23 - pos] : 1'b0;
            end
            sclk_p = sclk;
            cs_p = cs_n;
        end
    end

    task automatic run_scan(input logic [7:0] m, input int sk_base, input int ov_base,
                            input bit ref_sel, input int sd, input bit poke);
        logic [7:0] exp_cmd [128];
        int exp_n, g, ok_fix, ok_se, ok_ref, ok_on, ok_addr, first_bad;
        int exp_res [8];
        int sk [8];
        int ov [8];
        int n_before, waited;
        for (int c = 0; c < 8; c++) begin
            sk[c] = (sk_base < 0) ? 0 : (c + sk_base) % 4;
            ov[c] = (ov_base < 0) ? 7 : (c * 3 + ov_base) % 8;
            skip_r[c*CNT_W +: CNT_W] = CNT_W'(sk[c]);
            ovs_r[c*CNT_W +: CNT_W]  = CNT_W'(ov[c]);
            kcnt[c] = 0;
            exp_res[c] = 0;
        end
        ch_en = m;
        iref = ref_sel;
        seed = sd;
        log_n = 0;
        bad_half = 0;
        // expected stream
        exp_n = 0;
        g = 0;
        for (int c = 0; c < 8; c++) begin
            if (m[c]) begin
                int oe, n, sum, se;
                oe = (ov[c] == 0) ? 1 : ov[c];
                n = sk[c] + oe;
                se = (c == 0 || c == 2 || c == 6 || c == 7) ? 1 : 0;
                sum = 0;
                for (int k = 0; k < n; k++) begin
                    bit last;
                    last = (k == n - 1);
                    exp_cmd[exp_n] = 8'h80 | 8'(c << 4) | 8'(se << 2)
                                   | (last ? 8'h00 : (8'((se & int'(ref_sel)) << 1) | 8'h01));
                    exp_n++;
                    if (k >= sk[c]) sum += int'(mval(c, k, sd));
                end
                exp_res[g] = (sum + oe - 1) / oe;
                g++;
            end
        end
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (40) @(negedge clk);
            ch_en = 8'hFF;
            iref = ~ref_sel;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!done && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        chk(done == 1'b1, "R10 done seen", int'(done), 1);
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
        // command checks
        ok_fix = 1; ok_se = 1; ok_ref = 1; ok_on = 1; ok_addr = 1; first_bad = -1;
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            logic [7:0] a, e;
            a = log_cmd[i];
            e = exp_cmd[i];
            if (a[7] != 1'b1 || a[3] != 1'b0) ok_fix = 0;
            if (a[6:4] != e[6:4]) ok_addr = 0;
            if (a[2] != e[2]) ok_se = 0;
            if (a[1] != e[1]) ok_ref = 0;
            if (a[0] != e[0]) ok_on = 0;
            if (a != e && first_bad < 0) first_bad = i;
        end
        chk(log_n == exp_n, "R5 frame count", log_n, exp_n);
        chk(ok_fix == 1, "R1 start/width bits", ok_fix, 1);
        chk(ok_addr == 1, "R7 address order", ok_addr, 1);
        chk(ok_se == 1, "R2 single-ended bit", ok_se, 1);
        chk(ok_ref == 1, "R3 reference bit", ok_ref, 1);
        chk(ok_on == 1, "R4 power bits", ok_on, 1);
        if (first_bad >= 0)
            chk(0, "R1 first bad command", int'(log_cmd[first_bad]), int'(exp_cmd[first_bad]));
        for (int s = 0; s < 8; s++) begin
            int act;
            act = int'(result[s*12 +: 12]);
            if (s < g) chk(act == exp_res[s], "R6 averaged result", act, exp_res[s]);
            else       chk(act == 0, "R7 unused slot zero", act, 0);
        end
        chk(bad_half == 0, "R8 half period", bad_half, 0);
        if (exp_n > 0)
            chk(cs_rise_t - fall_t == longint'(CLK_T), "R9 cs release delay",
                int'(cs_rise_t - fall_t), CLK_T);
        n_before = log_n;
        repeat (40) @(negedge clk);
        chk(cs_n == 1'b1, "R11 no further scan (cs)", int'(cs_n), 1);
        chk(log_n == n_before, "R11 no further frames", log_n, n_before);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R12 reset cs_n", int'(cs_n), 1);
        chk(sclk == 1'b0, "R12 reset sclk", int'(sclk), 0);
        chk(done == 1'b0, "R12 reset done", int'(done), 0);
        chk(result == '0, "R12 reset results", 0, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // each channel alone, both reference selections
        for (int s = 0; s < 8; s++) begin
            run_scan(8'(1 << s), s, s + 1, 1'b1, s, 1'b0);
            run_scan(8'(1 << s), s + 1, s + 2, 1'b0, s + 20, 1'b0);
        end
        // empty mask: done with no frame (R10)
        run_scan(8'h00, 0, 1, 1'b1, 3, 1'b0);
        chk(log_n == 0, "R10 empty mask no frames", log_n, 0);
        // full scale sums, largest averaging (R6)
        run_scan(8'hFF, -1, -1, 1'b1, 200, 1'b0);
        run_scan(8'hFF, -1, -1, 1'b0, 201, 1'b0);
        // mixed masks, including zero oversampling counts (R5)
        for (int s = 0; s < 8; s++)
            run_scan(8'((s * 37 + 13) & 8'hFF), s, s, s[0], s + 40, 1'b0);
        // restart and input change during scan (R11)
        run_scan(8'hA5, 1, 2, 1'b1, 77, 1'b1);
        run_scan(8'h5A, 2, 5, 1'b0, 78, 1'b1);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule